// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Generator

This block is the digital core of a processor supply supervisor. It takes two synchronous supply-fault flags, a low-line indication and a battery-mode indication. From them it drives an active-low processor reset, the active-high complement of that reset, and an active-low watchdog fault flag. While either fault flag is raised, reset is held asserted. Once both clear, reset stays asserted for a fixed number of timebase ticks so that the supply and the processor can settle.

The watchdog input has three states. It arrives as a level plus a flag that marks the pin as disconnected. When the pin is disconnected the watchdog is disabled. Otherwise every rising or falling transition restarts the watchdog timer. If the level stays still for a full period, the fault flag drops and the block issues a reset pulse. That pulse repeats for each further period that expires. The period is either long or short, chosen by a select input, but the first period after any reset is always the long one.

All timers advance on a tick taken from a clock prescaler. The prescaler ratio, the reset stretch length and both watchdog periods are parameters. With the default values (divide by 64, 64 ticks of stretch, 512 and 16 ticks of period) a 64 kHz-class timebase gives about 4096 input clocks of stretch and about 1024 input clocks of short period.

Top module: `supervisor_wdt`

## Requirements
- R1: While `low_line_i` or `batt_mode_i` is 1, `rst_no` is 0 in the same cycle.
- R2: After both fault flags return to 0, `rst_no` stays 0 for RST_TICKS timebase ticks, with one tick every DIV clocks, and then rises to 1.
- R3: With `wd_short_i` = 1 and outside the first period after a reset, a watchdog level held unchanged for WD_SHORT ticks expires the watchdog.
- R4: The first watchdog period after any reset uses WD_LONG ticks, whatever the value of `wd_short_i`. `wd_short_i` = 0 selects WD_LONG at all times.
- R5: A rising or a falling transition of `wd_level_i`, taken through a two-flop synchroniser, restarts the watchdog period.
- R6: While `wd_float_i` is 1 the watchdog never expires.
- R7: On expiry `wd_fault_no` goes to 0 and `rst_no` is pulsed low for RST_TICKS ticks. The flag stays 0 and a new pulse follows each further expired period.
- R8: `wd_fault_no` returns to 1 on a synchronised transition of `wd_level_i` or when `low_line_i` is 1.
- R9: While `batt_mode_i` is 1, transitions on `wd_level_i` are ignored, `wd_fault_no` is held at 1 and `rst_no` is held at 0.
- R10: `rst_o` is at all times the inverse of `rst_no`.
- R11: While `arst_ni` is 0, `rst_no` is 0 and `wd_fault_no` is 1. After `arst_ni` is released a full reset stretch runs before `rst_no` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| arst_ni | input | 1 | Asynchronous power-on clear of the logic, active low |
| low_line_i | input | 1 | Supply below threshold flag, synchronous |
| batt_mode_i | input | 1 | Supply running from battery flag, synchronous |
| wd_level_i | input | 1 | Watchdog input level |
| wd_float_i | input | 1 | Watchdog input disconnected, disables the watchdog |
| wd_short_i | input | 1 | 1 selects the short watchdog period |
| rst_no | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wd_fault_no | output | 1 | Watchdog expired flag, active low |

## Verification
Stretch timing is tried twice, after the power-on clear and after a short low-line pulse. It is sampled just before the earliest release and just after the latest, which separates a correct tick count from one that is a tick short or long. The watchdog is held still with the short period selected straight after a reset, so a design that ignores the forced long period expires early. It is then toggled on both rising and falling levels, at intervals shorter than one period but longer in total, so that only a restarting timer survives. Battery mode, a floating input and a low-line pulse while the flag is low each show their forcing effect at the outputs. A repeated expiry without service confirms the periodic reset pulses.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    RG_IDLE    = 2'd0,
    RG_HOLD    = 2'd1,
    RG_STRETCH = 2'd2
  } rg_state_e;

  // Watchdog period in ticks: the long period is forced after a reset
  function automatic int unsigned wd_period_ticks(
    input logic        force_long,
    input logic        short_sel,
    input int unsigned long_ticks,
    input int unsigned short_ticks
  );
    if (force_long || !short_sel) return long_ticks;
    return short_ticks;
  endfunction

  // True when a counter at value cur completes a window of len ticks
  function automatic logic window_done(
    input int unsigned cur,
    input int unsigned len
  );
    return (cur + 1) >= len;
  endfunction

endpackage

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] cnt_q;
      assign tick_o = (cnt_q == DW'(DIV - 1));
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni)    cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic level_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-1:0], level_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign edge_o  = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_pkg::*;
#(
  parameter int unsigned RST_TICKS = 64
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic tick_i,
  input  logic fault_i,
  input  logic wd_expire_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(RST_TICKS + 1);

  rg_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = tick_i && window_done(int'(cnt_q), RST_TICKS);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      st_q  <= RG_STRETCH;
      cnt_q <= '0;
    end else if (fault_i) begin
      st_q  <= RG_HOLD;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        RG_HOLD, RG_STRETCH: begin
          st_q <= RG_STRETCH;
          if (last_tick) begin
            st_q  <= RG_IDLE;
            cnt_q <= '0;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (wd_expire_i) begin
            st_q  <= RG_STRETCH;
            cnt_q <= '0;
          end
        end
      endcase
    end
  end

  assign active_o = fault_i || (st_q != RG_IDLE);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int unsigned WD_LONG  = 512,
  parameter int unsigned WD_SHORT = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic tick_i,
  input  logic edge_i,
  input  logic float_i,
  input  logic rst_active_i,
  input  logic batt_i,
  input  logic low_line_i,
  input  logic short_sel_i,
  output logic expire_o,
  output logic long_o,
  output logic fault_no
);
  localparam int unsigned MAXP = (WD_LONG > WD_SHORT) ? WD_LONG : WD_SHORT;
  localparam int unsigned CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic          fault_nq;
  logic          enable;
  int unsigned   limit;

  assign enable   = !float_i && !rst_active_i && !batt_i;
  assign limit    = wd_period_ticks(long_q, short_sel_i, WD_LONG, WD_SHORT);
  assign expire_o = enable && tick_i && !edge_i && window_done(int'(cnt_q), limit);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                          cnt_q <= '0;
    else if (!enable || edge_i || expire_o) cnt_q <= '0;
    else if (tick_i)                       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)               long_q <= 1'b1;
    else if (rst_active_i)      long_q <= 1'b1;
    else if (edge_i || expire_o) long_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                            fault_nq <= 1'b1;
    else if (batt_i || low_line_i || edge_i) fault_nq <= 1'b1;
    else if (expire_o)                       fault_nq <= 1'b0;
  end

  assign long_o   = long_q;
  assign fault_no = fault_nq;
endmodule

// File: rtl/supervisor_wdt.sv
module supervisor_wdt #(
  parameter int unsigned DIV       = 64,
  parameter int unsigned RST_TICKS = 64,
  parameter int unsigned WD_LONG   = 512,
  parameter int unsigned WD_SHORT  = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic low_line_i,
  input  logic batt_mode_i,
  input  logic wd_level_i,
  input  logic wd_float_i,
  input  logic wd_short_i,
  output logic rst_no,
  output logic rst_o,
  output logic wd_fault_no
);
  logic tick;
  logic wd_level_s;
  logic wd_edge_raw;
  logic wd_edge;
  logic wd_expire;
  logic wd_long;
  logic rst_active;
  logic supply_fault;

  assign supply_fault = low_line_i || batt_mode_i;

  sup_prescaler #(.DIV(DIV)) u_pre (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .tick_o  (tick)
  );

  sup_wdi_sync #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .level_i (wd_level_i),
    .level_o (wd_level_s),
    .edge_o  (wd_edge_raw)
  );

  // transitions do not count while running from battery
  assign wd_edge = wd_edge_raw && !batt_mode_i;

  sup_watchdog #(.WD_LONG(WD_LONG), .WD_SHORT(WD_SHORT)) u_wd (
    .clk_i        (clk_i),
    .arst_ni      (arst_ni),
    .tick_i       (tick),
    .edge_i       (wd_edge),
    .float_i      (wd_float_i),
    .rst_active_i (rst_active),
    .batt_i       (batt_mode_i),
    .low_line_i   (low_line_i),
    .short_sel_i  (wd_short_i),
    .expire_o     (wd_expire),
    .long_o       (wd_long),
    .fault_no     (wd_fault_no)
  );

  sup_reset_gen #(.RST_TICKS(RST_TICKS)) u_rg (
    .clk_i       (clk_i),
    .arst_ni     (arst_ni),
    .tick_i      (tick),
    .fault_i     (supply_fault),
    .wd_expire_i (wd_expire),
    .active_o    (rst_active)
  );

  assign rst_no = !rst_active;
  assign rst_o  = rst_active;

  logic unused_level;
  assign unused_level = wd_level_s;
endmodule

// File: rtl/supervisor_wdt_checker.sv
module supervisor_wdt_checker (
  input logic clk_i,
  input logic arst_ni,
  input logic low_line_i,
  input logic batt_mode_i,
  input logic wd_float_i,
  input logic rst_no,
  input logic rst_o,
  input logic wd_fault_no,
  input logic wd_edge,
  input logic wd_expire,
  input logic wd_long
);
  // R1
  p_rst_on_fault_r1: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (low_line_i || batt_mode_i) |-> !rst_no);

  // R2: reset does not release in the cycle after a fault clears
  p_stretch_holds_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
    ($fell(low_line_i) && !batt_mode_i) |=> !rst_no);

  // R4: any reset forces the long period for the next window
  p_long_after_rst_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !rst_no |=> wd_long);

  // R6
  p_float_quiet_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wd_float_i |-> !wd_expire);

  // R7
  p_expire_fault_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (wd_expire && !low_line_i && !batt_mode_i) |=> (!wd_fault_no && !rst_no));

  // R8
  p_edge_clears_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wd_edge |=> wd_fault_no);

  p_lowline_clears_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    low_line_i |=> wd_fault_no);

  // R9
  p_batt_flag_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
    batt_mode_i |=> wd_fault_no);

  p_batt_no_edge_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
    batt_mode_i |-> !wd_edge);

  // R10
  p_compl_r10: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_o != rst_no);
endmodule

bind supervisor_wdt supervisor_wdt_checker u_chk (
  .clk_i       (clk_i),
  .arst_ni     (arst_ni),
  .low_line_i  (low_line_i),
  .batt_mode_i (batt_mode_i),
  .wd_float_i  (wd_float_i),
  .rst_no      (rst_no),
  .rst_o       (rst_o),
  .wd_fault_no (wd_fault_no),
  .wd_edge     (wd_edge),
  .wd_expire   (wd_expire),
  .wd_long     (wd_long)
);

// File: tb/supervisor_wdt_test.sv
module supervisor_wdt_test;
  localparam int unsigned DIV       = 4;
  localparam int unsigned RST_TICKS = 8;
  localparam int unsigned WD_LONG   = 24;
  localparam int unsigned WD_SHORT  = 6;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic ll = 1'b0, bt = 1'b0, lv = 1'b0, fl = 1'b1, sh = 1'b0;
  logic rst_n, rst_h, wdo_n;

  int checks = 0;
  int fails  = 0;
  int compl_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  supervisor_wdt #(.DIV(DIV), .RST_TICKS(RST_TICKS), .WD_LONG(WD_LONG), .WD_SHORT(WD_SHORT)) uut (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .low_line_i  (ll),
    .batt_mode_i (bt),
    .wd_level_i  (lv),
    .wd_float_i  (fl),
    .wd_short_i  (sh),
    .rst_no      (rst_n),
    .rst_o       (rst_h),
    .wd_fault_no (wdo_n)
  );

  typedef struct packed {
    logic       ll;
    logic       bt;
    logic       fl;
    logic       lv;
    logic       sh;
    logic [15:0] wait_cyc;
    logic       exp_rst_n;
    logic       exp_wdo_n;
    logic [7:0] req;
  } vec_t;

  // Windows with DIV=4: stretch 29..33 cycles, long 93..97, short 21..27 after a drive
  localparam vec_t VECS [24] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 16'd20,  1'b0,1'b1, 8'd11}, // R11 stretch still running
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 16'd16,  1'b1,1'b1, 8'd2 }, // R2 released
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 16'd3,   1'b0,1'b1, 8'd1 }, // R1 low-line
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 16'd25,  1'b0,1'b1, 8'd2 }, // R2 before earliest release
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 16'd10,  1'b1,1'b1, 8'd2 }, // R2 after latest release
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 16'd200, 1'b1,1'b1, 8'd6 }, // R6 floating never expires
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd50,  1'b1,1'b1, 8'd4 }, // R4 short ignored after reset
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd40,  1'b1,1'b1, 8'd4 }, // R4 long not yet over
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd10,  1'b0,1'b0, 8'd7 }, // R7 expiry
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd40,  1'b1,1'b0, 8'd7 }, // R7 pulse over, flag stays low
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd60,  1'b1,1'b0, 8'd4 }, // R4 long again after pulse
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd30,  1'b0,1'b0, 8'd7 }, // R7 repeated pulse
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 16'd5,   1'b0,1'b1, 8'd8 }, // R8 transition clears flag
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 16'd30,  1'b1,1'b1, 8'd2 }, // R2 pulse released
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd15,  1'b1,1'b1, 8'd5 }, // R5 falling restarts
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 16'd15,  1'b1,1'b1, 8'd5 }, // R5 rising restarts
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 16'd5,   1'b1,1'b1, 8'd3 }, // R3 short not yet over
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 16'd15,  1'b0,1'b0, 8'd3 }, // R3 short expired
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 16'd4,   1'b0,1'b1, 8'd9 }, // R9 battery forces
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 16'd10,  1'b0,1'b1, 8'd9 }, // R9 toggle ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd40,  1'b1,1'b1, 8'd2 }, // R2 after battery
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd100, 1'b0,1'b0, 8'd7 }, // R7 long expiry
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 16'd3,   1'b0,1'b1, 8'd8 }, // R8 low-line clears flag
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 16'd40,  1'b1,1'b1, 8'd2 }  // R2 released
  };

  task automatic chk(input logic act, input logic exp, input string what, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R10 monitored on every falling edge
  always @(negedge clk) if (arst_n && !done && (rst_h === rst_n)) compl_bad++;

  initial begin
    cycles(3);
    chk(rst_n, 1'b0, "rst_no during clear",     11); // R11
    chk(rst_h, 1'b1, "rst_o during clear",      11); // R11
    chk(wdo_n, 1'b1, "wd_fault_no during clear", 11); // R11
    arst_n = 1'b1;
    for (int k = 0; k < 24; k++) begin
      ll = VECS[k].ll; bt = VECS[k].bt; fl = VECS[k].fl;
      lv = VECS[k].lv; sh = VECS[k].sh;
      cycles(int'(VECS[k].wait_cyc));
      chk(rst_n, VECS[k].exp_rst_n, $sformatf("vec %0d rst_no", k), int'(VECS[k].req));
      chk(wdo_n, VECS[k].exp_wdo_n, $sformatf("vec %0d wd_fault_no", k), int'(VECS[k].req));
    end
    // directed: battery during an active fault flag keeps reset and flag (R9)
    bt = 1'b1; lv = 1'b1;
    cycles(6);
    chk(rst_n, 1'b0, "battery with toggle rst_no", 9);   // R9
    chk(wdo_n, 1'b1, "battery with toggle flag",   9);   // R9
    done = 1;
    checks++;
    if (compl_bad != 0) begin
      fails++;
      $display("FAIL R10 complement mismatches: actual %0d expected 0", compl_bad);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule